// File: doc/BRIEF.md
# Row Triple-Buffer Streaming Sequencer

This controller walks a two-dimensional grid, one row at a time, through three row buffers in a local scratchpad. The buffers take the roles previous, current and next. The sequencer issues row loads and row stores to an external memory model. It also triggers two compute passes: a horizontal pass over one row and a vertical pass over a pair of adjacent rows. The arithmetic and the memory live outside this block. The sequencer only orders the work.

A run starts with a pulse on `start_i` while the block is idle, with the row count N on `num_rows_i`. Rows 0 and 1 are fetched first, and then row 0 gets a horizontal pass. After that, iterations n = 1 .. N-1 follow. In each iteration the vertical pass over rows n-1 and n overlaps the prefetch of row n+1. When that pass is finished, the horizontal pass on row n overlaps the writeback of row n-1. Then the finished buffer is cleared and the buffer roles rotate.

Buffers are renamed, never copied, so row r always sits in buffer r mod 3. Memory requests leave on a valid/ready channel. The sequencer holds a request and all of its fields stable until `mreq_ready_i` is seen high. Memory back-pressure therefore only stretches the schedule and never reorders it. Completions come back as single-cycle acknowledgements that are tagged load or store.

Top module: `row_tribuf_seq`

## Requirements
- R1: After reset, and whenever idle, `busy_o` is 0 and no request, pass start, clear or done is asserted.
- R2: A start is accepted only while idle and with N >= 2. A start with N < 2, or a start while busy, has no effect.
- R3: A run first requests row 0 and then row 1. The horizontal pass on row 0 starts only after both loads are acknowledged.
- R4: In iteration n, the vertical pass (row field n) starts in the same cycle that the load request for row n+1 becomes valid. It starts only after the row-n load acknowledgement and the horizontal pass on row n-1 have completed.
- R5: The horizontal pass on row n (n >= 1) starts only after the vertical pass of iteration n is done. It starts in the same cycle that the store request for row n-1 becomes valid.
- R6: Row r is loaded into, stored from and processed in buffer r mod 3. The vertical pass names buffer (n-1) mod 3 as previous and n mod 3 as current.
- R7: The clear strobe for row n-1's buffer comes only after that row's store is acknowledged. It comes before any new load is issued into that buffer.
- R8: Loads and stores each cover rows 0 .. N-1 exactly once and in ascending order. The last row is stored after its horizontal pass on the final iteration. No request names a row at or beyond N.
- R9: On the request channel a transfer occurs when valid and ready are both high. While valid is high and ready is low, valid, row, buffer and kind (`mreq_store_o`: 1 store, 0 load) stay unchanged.
- R10: `done_o` is a single-cycle pulse. It is raised only once every store has been acknowledged, and `busy_o` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run start pulse |
| num_rows_i | input | ROW_W | Row count N, sampled with the start |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request ready |
| mreq_store_o | output | 1 | 1 = store, 0 = load |
| mreq_row_o | output | ROW_W | Grid row of the request |
| mreq_buf_o | output | 2 | Scratchpad buffer of the request |
| mack_valid_i | input | 1 | Completion acknowledgement |
| mack_store_i | input | 1 | Acknowledged kind, 1 = store |
| hpass_start_o | output | 1 | Horizontal pass start pulse |
| hpass_row_o | output | ROW_W | Row of the horizontal pass |
| hpass_buf_o | output | 2 | Buffer of the horizontal pass |
| hpass_done_i | input | 1 | Horizontal pass finished |
| vpass_start_o | output | 1 | Vertical pass start pulse |
| vpass_row_o | output | ROW_W | Lower row n of the pair (n-1, n) |
| vpass_prev_buf_o | output | 2 | Buffer holding row n-1 |
| vpass_cur_buf_o | output | 2 | Buffer holding row n |
| vpass_done_i | input | 1 | Vertical pass finished |
| clr_o | output | 1 | Clear strobe for a finished buffer |
| clr_buf_o | output | 2 | Buffer to clear |

## Verification
The shortest grids, N = 2 and N = 3, run with ready held high. They separate the final-iteration path, which stores two rows and prefetches nothing, from a steady iteration. Throttled ready, random pass latencies and random acknowledgement delays shift the relative order of pass completions, store acknowledgements and load acknowledgements. This shows whether each start really waits on its own dependencies and not on a lucky timing. Starts with N of 0 or 1, and a start injected in the middle of a run, separate an ignored start from a restarted one. Every event is checked against the buffer index r mod 3 and against the ascending row order.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  localparam int unsigned NBUF = 3;
  typedef logic [1:0] bidx_t;
  typedef enum logic [3:0] {
    S_IDLE, S_LD1, S_WINIT, S_WH0, S_VGO, S_WV, S_WH, S_WACK, S_CLR, S_DONE
  } seq_state_e;
endpackage

// File: rtl/rowseq_roles.sv
module rowseq_roles
  import rowseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_i,
  input  logic  rot_i,
  output bidx_t prev_o,
  output bidx_t cur_o,
  output bidx_t nxt_o
);
  // slot 0 = previous, 1 = current, 2 = next; rotation renames, never copies
  bidx_t role_q [NBUF];

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      for (int i = 0; i < int'(NBUF); i++) role_q[i] <= bidx_t'(i);
    end else if (rot_i) begin
      for (int i = 0; i < int'(NBUF); i++) role_q[i] <= role_q[(i + 1) % int'(NBUF)];
    end
  end

  assign prev_o = role_q[0];
  assign cur_o  = role_q[1];
  assign nxt_o  = role_q[2];
endmodule

// File: rtl/rowseq_req_slot.sv
module rowseq_req_slot
  import rowseq_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             set_store_i,
  input  logic [ROW_W-1:0] set_row_i,
  input  bidx_t            set_buf_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             store_o,
  output logic [ROW_W-1:0] row_o,
  output bidx_t            buf_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      store_o <= 1'b0;
      row_o   <= '0;
      buf_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      store_o <= set_store_i;
      row_o   <= set_row_i;
      buf_o   <= set_buf_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rowseq_pend_cnt.sv
module rowseq_pend_cnt #(
  parameter int CW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/row_tribuf_seq.sv
module row_tribuf_seq
  import rowseq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int PEND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ROW_W-1:0] num_rows_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mreq_valid_o,
  input  logic             mreq_ready_i,
  output logic             mreq_store_o,
  output logic [ROW_W-1:0] mreq_row_o,
  output logic [1:0]       mreq_buf_o,
  input  logic             mack_valid_i,
  input  logic             mack_store_i,
  output logic             hpass_start_o,
  output logic [ROW_W-1:0] hpass_row_o,
  output logic [1:0]       hpass_buf_o,
  input  logic             hpass_done_i,
  output logic             vpass_start_o,
  output logic [ROW_W-1:0] vpass_row_o,
  output logic [1:0]       vpass_prev_buf_o,
  output logic [1:0]       vpass_cur_buf_o,
  input  logic             vpass_done_i,
  output logic             clr_o,
  output logic [1:0]       clr_buf_o
);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);
  localparam logic [ROW_W-1:0] MIN_ROWS = ROW_W'(2);
  localparam int NKIND = 2;   // 0 = load, 1 = store

  seq_state_e st_q, st_d;
  logic [ROW_W-1:0] n_q, last_q;
  logic h_fin_q, v_fin_q;
  bidx_t role_prev, role_cur, role_nxt;
  logic roles_init, roles_rot;
  logic req_set, req_store;
  logic [ROW_W-1:0] req_row;
  bidx_t req_buf;
  logic h_go, v_go, n_inc, start_ok;
  logic [ROW_W-1:0] h_row_d;
  bidx_t h_buf_d;
  logic [NKIND-1:0] pend_zero;
  logic req_fire;

  rowseq_roles u_roles (
    .clk(clk), .rst_n(rst_n), .init_i(roles_init), .rot_i(roles_rot),
    .prev_o(role_prev), .cur_o(role_cur), .nxt_o(role_nxt)
  );

  rowseq_req_slot #(.ROW_W(ROW_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .set_store_i(req_store),
    .set_row_i(req_row), .set_buf_i(req_buf), .ready_i(mreq_ready_i),
    .valid_o(mreq_valid_o), .store_o(mreq_store_o), .row_o(mreq_row_o),
    .buf_o(mreq_buf_o)
  );

  assign req_fire = mreq_valid_o && mreq_ready_i;

  for (genvar g = 0; g < NKIND; g++) begin : g_pend
    rowseq_pend_cnt #(.CW(PEND_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc_i(req_fire && (mreq_store_o == 1'(g))),
      .dec_i(mack_valid_i && (mack_store_i == 1'(g))),
      .zero_o(pend_zero[g])
    );
  end

  always_comb begin
    st_d       = st_q;
    req_set    = 1'b0;
    req_store  = 1'b0;
    req_row    = '0;
    req_buf    = role_prev;
    roles_init = 1'b0;
    roles_rot  = 1'b0;
    h_go       = 1'b0;
    h_row_d    = n_q;
    h_buf_d    = role_cur;
    v_go       = 1'b0;
    n_inc      = 1'b0;
    start_ok   = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i && num_rows_i >= MIN_ROWS) begin
        start_ok   = 1'b1;
        roles_init = 1'b1;
        req_set    = 1'b1;
        req_buf    = bidx_t'(0);
        st_d       = S_LD1;
      end
      S_LD1: if (!mreq_valid_o) begin
        req_set = 1'b1;
        req_row = ROW_ONE;
        req_buf = role_cur;
        st_d    = S_WINIT;
      end
      S_WINIT: if (!mreq_valid_o && pend_zero[0]) begin
        h_go    = 1'b1;
        h_row_d = '0;
        h_buf_d = role_prev;
        st_d    = S_WH0;
      end
      S_WH0: if (h_fin_q) st_d = S_VGO;
      S_VGO: begin
        v_go = 1'b1;
        if (n_q != last_q) begin
          req_set = 1'b1;
          req_row = n_q + ROW_ONE;
          req_buf = role_nxt;
        end
        st_d = S_WV;
      end
      S_WV: if (v_fin_q && !mreq_valid_o) begin
        h_go      = 1'b1;
        req_set   = 1'b1;
        req_store = 1'b1;
        req_row   = n_q - ROW_ONE;
        req_buf   = role_prev;
        st_d      = S_WH;
      end
      S_WH: if (h_fin_q && !mreq_valid_o) begin
        if (n_q == last_q) begin
          req_set   = 1'b1;
          req_store = 1'b1;
          req_row   = n_q;
          req_buf   = role_cur;
        end
        st_d = S_WACK;
      end
      S_WACK: if (!mreq_valid_o && pend_zero[0] && pend_zero[1]) st_d = S_CLR;
      S_CLR: begin
        if (n_q == last_q) st_d = S_DONE;
        else begin
          roles_rot = 1'b1;
          n_inc     = 1'b1;
          st_d      = S_VGO;
        end
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q             <= S_IDLE;
      n_q              <= '0;
      last_q           <= '0;
      hpass_start_o    <= 1'b0;
      vpass_start_o    <= 1'b0;
      hpass_row_o      <= '0;
      hpass_buf_o      <= '0;
      vpass_row_o      <= '0;
      vpass_prev_buf_o <= '0;
      vpass_cur_buf_o  <= '0;
      h_fin_q          <= 1'b0;
      v_fin_q          <= 1'b0;
    end else begin
      st_q          <= st_d;
      hpass_start_o <= h_go;
      vpass_start_o <= v_go;
      if (h_go) begin
        hpass_row_o <= h_row_d;
        hpass_buf_o <= h_buf_d;
      end
      if (v_go) begin
        vpass_row_o      <= n_q;
        vpass_prev_buf_o <= role_prev;
        vpass_cur_buf_o  <= role_cur;
      end
      if (start_ok) begin
        n_q    <= ROW_ONE;
        last_q <= num_rows_i - ROW_ONE;
      end else if (n_inc) begin
        n_q <= n_q + ROW_ONE;
      end
      if (h_go) h_fin_q <= 1'b0;
      else if (hpass_done_i) h_fin_q <= 1'b1;
      if (v_go) v_fin_q <= 1'b0;
      else if (vpass_done_i) v_fin_q <= 1'b1;
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_DONE);
  assign clr_o     = (st_q == S_CLR);
  assign clr_buf_o = role_prev;
endmodule

module row_tribuf_seq_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             mreq_valid_o,
  input logic             mreq_ready_i,
  input logic             mreq_store_o,
  input logic [ROW_W-1:0] mreq_row_o,
  input logic [1:0]       mreq_buf_o,
  input logic             mack_valid_i,
  input logic             mack_store_i,
  input logic             hpass_start_o,
  input logic             vpass_start_o,
  input logic [1:0]       vpass_prev_buf_o,
  input logic [1:0]       vpass_cur_buf_o,
  input logic             clr_o
);
  logic [2:0] st_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) st_pend <= '0;
    else st_pend <= st_pend + 3'((mreq_valid_o && mreq_ready_i && mreq_store_o) ? 1 : 0)
                            - 3'((mack_valid_i && mack_store_i) ? 1 : 0);
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_row_o)
      && $stable(mreq_buf_o) && $stable(mreq_store_o));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mreq_valid_o && !hpass_start_o && !vpass_start_o && !clr_o);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  a_r10_stores_settled: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> st_pend == 3'd0);
  a_r7_clear_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> st_pend == 3'd0 && !mreq_valid_o);
  a_r6_vpass_bufs: assert property (@(posedge clk) disable iff (!rst_n)
    vpass_start_o |-> vpass_prev_buf_o != vpass_cur_buf_o
      && vpass_prev_buf_o != 2'd3 && vpass_cur_buf_o != 2'd3);
  a_r6_req_buf_range: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> mreq_buf_o != 2'd3);
  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hpass_start_o, vpass_start_o, clr_o, done_o}));
endmodule

bind row_tribuf_seq row_tribuf_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
  .mreq_store_o(mreq_store_o), .mreq_row_o(mreq_row_o), .mreq_buf_o(mreq_buf_o),
  .mack_valid_i(mack_valid_i), .mack_store_i(mack_store_i),
  .hpass_start_o(hpass_start_o), .vpass_start_o(vpass_start_o),
  .vpass_prev_buf_o(vpass_prev_buf_o), .vpass_cur_buf_o(vpass_cur_buf_o),
  .clr_o(clr_o)
);

// File: tb/row_tribuf_seq_bench.sv
`timescale 1ns/1ps
module row_tribuf_seq_bench;
  localparam int ROW_W = 8;
  localparam int MAXR  = 64;
  localparam int QN    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [ROW_W-1:0] num_rows_i = '0;
  logic busy_o, done_o, mreq_valid_o, mreq_store_o;
  logic mreq_ready_i = 1'b0;
  logic [ROW_W-1:0] mreq_row_o, hpass_row_o, vpass_row_o;
  logic [1:0] mreq_buf_o, hpass_buf_o, vpass_prev_buf_o, vpass_cur_buf_o, clr_buf_o;
  logic mack_valid_i = 1'b0, mack_store_i = 1'b0;
  logic hpass_start_o, vpass_start_o, clr_o;
  logic hpass_done_i = 1'b0, vpass_done_i = 1'b0;

  always #2 clk = ~clk;

  row_tribuf_seq #(.ROW_W(ROW_W)) u_row_tribuf_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .num_rows_i(num_rows_i),
    .busy_o(busy_o), .done_o(done_o),
    .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
    .mreq_store_o(mreq_store_o), .mreq_row_o(mreq_row_o), .mreq_buf_o(mreq_buf_o),
    .mack_valid_i(mack_valid_i), .mack_store_i(mack_store_i),
    .hpass_start_o(hpass_start_o), .hpass_row_o(hpass_row_o), .hpass_buf_o(hpass_buf_o),
    .hpass_done_i(hpass_done_i),
    .vpass_start_o(vpass_start_o), .vpass_row_o(vpass_row_o),
    .vpass_prev_buf_o(vpass_prev_buf_o), .vpass_cur_buf_o(vpass_cur_buf_o),
    .vpass_done_i(vpass_done_i), .clr_o(clr_o), .clr_buf_o(clr_buf_o)
  );

  int n_chk = 0, n_fail = 0;
  bit ld_ack [MAXR];
  bit st_ack [MAXR];
  bit h_fin [MAXR];
  bit v_fin [MAXR];
  bit free_b [3];
  int nrows, next_load, next_store, next_h, next_v, next_clr, done_seen;
  int h_tmr, h_row, v_tmr, v_row;
  int q_t [QN];
  bit q_on [QN];
  bit q_st [QN];
  int q_row [QN];
  int run_cyc, poke_at, rdy_pct;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int b3(int r);
    return r % 3;
  endfunction

  task automatic clear_board();
    for (int i = 0; i < MAXR; i++) begin
      ld_ack[i] = 0; st_ack[i] = 0; h_fin[i] = 0; v_fin[i] = 0;
    end
    for (int i = 0; i < 3; i++) free_b[i] = 1;
    for (int i = 0; i < QN; i++) q_on[i] = 0;
    next_load = 0; next_store = 0; next_h = 0; next_v = 1; next_clr = 0;
    done_seen = 0; h_tmr = 0; v_tmr = 0; run_cyc = 0;
  endtask

  task automatic tick();
    int r;
    bit acked;
    @(negedge clk);
    run_cyc++;
    start_i = (run_cyc == poke_at);
    if (start_i) num_rows_i = ROW_W'(2);
    mack_valid_i = 0; mack_store_i = 0; hpass_done_i = 0; vpass_done_i = 0;
    if (h_tmr > 0) begin
      h_tmr--;
      if (h_tmr == 0) begin hpass_done_i = 1; h_fin[h_row] = 1; end
    end
    if (v_tmr > 0) begin
      v_tmr--;
      if (v_tmr == 0) begin vpass_done_i = 1; v_fin[v_row] = 1; end
    end
    if (hpass_start_o) begin
      r = next_h;
      chk(int'(hpass_row_o) == r, "R5 hpass row", int'(hpass_row_o), r);
      chk(int'(hpass_buf_o) == b3(r), "R6 hpass buf", int'(hpass_buf_o), b3(r));
      if (r == 0) chk(ld_ack[0] && ld_ack[1], "R3 rows 0,1 acked before H0", 0, 1);
      else begin
        chk(v_fin[r % MAXR], "R5 H after V done", 0, 1);
        chk(mreq_valid_o && mreq_store_o && int'(mreq_row_o) == r - 1,
            "R5 store issued with H", int'(mreq_row_o), r - 1);
      end
      next_h++; h_row = r % MAXR; h_tmr = 1 + int'($urandom % 5);
    end
    if (vpass_start_o) begin
      r = next_v;
      chk(int'(vpass_row_o) == r, "R4 vpass row", int'(vpass_row_o), r);
      chk(int'(vpass_prev_buf_o) == b3(r - 1), "R6 vpass prev buf", int'(vpass_prev_buf_o), b3(r - 1));
      chk(int'(vpass_cur_buf_o) == b3(r), "R6 vpass cur buf", int'(vpass_cur_buf_o), b3(r));
      chk(ld_ack[r % MAXR] && h_fin[(r - 1) % MAXR], "R4 V prerequisites", 0, 1);
      if (r < nrows - 1)
        chk(mreq_valid_o && !mreq_store_o && int'(mreq_row_o) == r + 1,
            "R4 prefetch issued with V", int'(mreq_row_o), r + 1);
      else chk(!mreq_valid_o, "R8 no prefetch on final iteration", int'(mreq_valid_o), 0);
      next_v++; v_row = r % MAXR; v_tmr = 1 + int'($urandom % 5);
    end
    if (clr_o) begin
      chk(int'(clr_buf_o) == b3(next_clr), "R7 clear buffer", int'(clr_buf_o), b3(next_clr));
      chk(st_ack[next_clr % MAXR], "R7 clear after store ack", 0, 1);
      free_b[clr_buf_o % 3] = 1;
      next_clr++;
    end
    if (done_o) begin
      done_seen++;
      acked = 1;
      for (int i = 0; i < nrows; i++) if (!st_ack[i]) acked = 0;
      chk(acked && next_store == nrows, "R10 done after all stores", next_store, nrows);
      chk(next_clr == nrows - 1, "R7 clears per run", next_clr, nrows - 1);
    end
    // acknowledgements, at most one per cycle
    for (int i = 0; i < QN; i++) if (q_on[i]) q_t[i]--;
    acked = 0;
    for (int i = 0; i < QN; i++) begin
      if (!acked && q_on[i] && q_t[i] <= 0) begin
        acked = 1; q_on[i] = 0;
        mack_valid_i = 1; mack_store_i = q_st[i];
        if (q_st[i]) st_ack[q_row[i]] = 1; else ld_ack[q_row[i]] = 1;
      end
    end
    // request channel
    mreq_ready_i = (int'($urandom % 100) < rdy_pct);
    if (mreq_valid_o && mreq_ready_i) begin
      r = int'(mreq_row_o);
      chk(int'(mreq_buf_o) == b3(r), "R6 request buffer", int'(mreq_buf_o), b3(r));
      if (!mreq_store_o) begin
        chk(r == next_load && r < nrows, "R8 load row order", r, next_load);
        chk(free_b[mreq_buf_o % 3], "R7 load into cleared buffer", 0, 1);
        free_b[mreq_buf_o % 3] = 0;
        next_load++;
      end else begin
        chk(r == next_store && r < nrows, "R8 store row order", r, next_store);
        if (r < nrows - 1) chk(v_fin[(r + 1) % MAXR], "R5 store after V", 0, 1);
        else chk(h_fin[r % MAXR], "R8 last row stored after H", 0, 1);
        next_store++;
      end
      for (int i = 0; i < QN; i++) begin
        if (!q_on[i]) begin
          q_on[i] = 1; q_st[i] = mreq_store_o; q_row[i] = r % MAXR;
          q_t[i] = 1 + int'($urandom % 6);
          break;
        end
      end
    end
  endtask

  task automatic run_seq(int n, int pct, int poke);
    clear_board();
    nrows = n; rdy_pct = pct; poke_at = poke;
    @(negedge clk);
    start_i = 1; num_rows_i = ROW_W'(n);
    tick();
    chk(busy_o == 1'b1, "R2 start accepted", int'(busy_o), 1);
    while (done_seen == 0 && run_cyc < 4000) tick();
    if (done_seen == 0) chk(0, "R10 watchdog per run", run_cyc, 4000);
    repeat (4) tick();
    chk(done_seen == 1, "R10 single done pulse", done_seen, 1);
    chk(!busy_o, "R10 idle after done", int'(busy_o), 0);
    chk(next_load == n, "R8 all rows loaded", next_load, n);
    chk(next_h == n && next_v == n, "R8 pass count", next_h, n);
  endtask

  task automatic ignored_start(int n);
    @(negedge clk);
    start_i = 1; num_rows_i = ROW_W'(n);
    @(negedge clk);
    start_i = 0;
    repeat (3) begin
      chk(!busy_o && !mreq_valid_o, "R2 start with N<2 ignored", int'(busy_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy_o && !mreq_valid_o && !done_o, "R1 state in reset", int'(busy_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !mreq_valid_o && !hpass_start_o && !vpass_start_o && !clr_o,
        "R1 idle after reset", int'(mreq_valid_o), 0);
    run_seq(2, 100, 0);
    run_seq(3, 100, 0);
    run_seq(4, 30, 0);
    ignored_start(1);
    ignored_start(0);
    run_seq(6, 60, 15);
    for (int i = 0; i < 12; i++) run_seq(2 + int'($urandom % 30), 20 + int'($urandom % 81), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL R10 global watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule